// File: doc/BRIEF.md
# Receive Byte Queue with Data-Ready Event

This block sits between a serial receiver and the bus side of a UART. Each byte the deserializer finishes is offered on a valid strobe. While reception is running and there is room, the byte is placed into a small circular store of six entries. Software pulls bytes out one at a time by reading a data port. A sticky data-ready event flag tells software that a byte is waiting. The flag is raised whenever a byte lands in the store. After each pop it is raised again if bytes are still waiting, so software can service the queue in a clear-flag, read-byte loop.

Reception is started and stopped by one-cycle strobes. A stopped queue accepts nothing and refuses pops, but it keeps the bytes it already holds. Reading the data port never stalls. When the queue is empty or stopped, the read returns whatever byte is stored at the current head slot and leaves the queue as it was. The block reports how much free space it can offer the receiver and how many bytes it holds.

Top module: `rx_byte_queue`

## Requirements
- R1: After a synchronous active-low reset, the fill count is 0, the free-space output is 0 (reception stopped), the ready flag is 0 and the head slot is slot 0.
- R2: An offered byte is accepted only when reception is running and the fill count is below 6. Each accepted byte raises the fill count by one, and the count never exceeds 6.
- R3: A byte offered while reception is stopped or the queue holds 6 bytes is dropped without any trace. The fill count and the ready flag do not change.
- R4: Every accepted byte sets the ready flag on the clock edge that stores it.
- R5: The free-space output equals 6 minus the fill count while reception is running, and 0 while it is stopped.
- R6: The data port always shows the byte at the head slot, so bytes leave in the order they arrived.
- R7: A read pops only when reception is running and the fill count is nonzero. A pop moves the head to the next slot, wrapping from slot 5 to slot 0, and lowers the count by one.
- R8: A pop that leaves at least one byte in the queue sets the ready flag again. A pop that empties the queue does not set it.
- R9: The ready flag is cleared only by a flag write whose 32-bit data is zero, and any nonzero write leaves it unchanged. If a set and a zero write fall in the same cycle, the flag ends up set.
- R10: An accepted byte and a pop in the same cycle leave the fill count unchanged and keep the arrival order.
- R11: A start strobe sets reception running and a stop strobe stops it. If both arrive in one cycle, stop wins. Stopping keeps the stored bytes.
- R12: A read of an empty queue returns the byte stored at the head slot and changes neither the fill count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start_i | input | 1 | Start-reception strobe |
| rx_stop_i | input | 1 | Stop-reception strobe |
| rx_vld_i | input | 1 | Receiver offers a byte this cycle |
| rx_byte_i | input | DATA_W (8) | Offered byte |
| rxd_rd_i | input | 1 | Bus read of the data port |
| rxd_o | output | DATA_W (8) | Byte at the head slot |
| rdy_wr_i | input | 1 | Bus write to the ready flag |
| rdy_wdata_i | input | BUS_W (32) | Data of the flag write |
| rdy_flag_o | output | 1 | Data-ready event flag |
| space_o | output | CNT_W (3) | Free space offered to the receiver |
| fill_o | output | CNT_W (3) | Bytes held |

## Verification
The data port is combinational from the head pointer and the store. The bench therefore checks `rxd_o` one time step after it raises the read strobe, in the same cycle as the read. Fill count, free space and flag are registered. Their effect shows one edge after the strobe, so the bench drives inputs on the falling edge and samples those outputs on the next falling edge. The expected bytes come from a queue model in the bench that follows only the accept and pop rules in the requirements.

// File: rtl/rxq_pkg.sv
// Package: shared types for the receive byte queue.
// Assumes: nothing beyond IEEE 1800-2017.
package rxq_pkg;

    // Reception state held by the control block.
    typedef enum logic {
        RXS_STOPPED = 1'b0,
        RXS_RUNNING = 1'b1
    } rx_state_e;

    // Per-cycle decisions that the control block hands to store and flag logic.
    typedef struct packed {
        logic accept;   // byte written into the store this cycle
        logic pop;      // head advances this cycle
        logic rearm;    // pop leaves data behind
    } rxq_step_t;

endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Holds DEPTH bytes. There is one write port at a slot index and one
// combinational read port at a slot index.
// Assumes: wr_slot_i and rd_slot_i stay below DEPTH. The entries are not reset,
// because their contents matter only once a byte has been written.
module rxq_store #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_slot_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_slot_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] entry_q [DEPTH];

    // One register per slot, loaded when the write targets it.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_slot_i == PTR_W'(gi))) begin
                entry_q[gi] <= wr_data_i;
            end
        end
    end

    // Read multiplexer: selects the head slot.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_slot_i == PTR_W'(i)) begin
                rd_data_o = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
// Module: rxq_ctrl
// Keeps the run/stop state, the head pointer and the fill count. It decides
// each cycle whether to accept and whether to pop.
// Assumes: strobes are synchronous to clk. Stop has priority over start.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 6,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic             rd_i,
    output logic             running_o,
    output rxq_step_t        step_o,
    output logic [PTR_W-1:0] wr_slot_o,
    output logic [PTR_W-1:0] rd_slot_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    rx_state_e         state_q, state_d;
    logic [PTR_W-1:0]  head_q, head_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [SUM_W-1:0]  tail_sum;
    logic              accept, pop;

    // Run/stop state decode: stop beats start.
    always_comb begin
        state_d = state_q;
        if (start_i) state_d = RXS_RUNNING;
        if (stop_i)  state_d = RXS_STOPPED;
    end

    // Accept and pop decisions from the current state.
    always_comb begin
        accept = (state_q == RXS_RUNNING) && byte_vld_i && (count_q < DEPTH_C);
        pop    = (state_q == RXS_RUNNING) && rd_i && (count_q != '0);
    end

    // Next head pointer and count, covering accept and pop together.
    always_comb begin
        head_d = head_q;
        if (pop) begin
            head_d = (head_q == LAST_SLOT) ? '0 : head_q + PTR_W'(1);
        end
        count_d = count_q;
        case ({accept, pop})
            2'b10:   count_d = count_q + CNT_W'(1);
            2'b01:   count_d = count_q - CNT_W'(1);
            default: count_d = count_q;
        endcase
    end

    // Tail slot: head plus count, folded back into the range 0..DEPTH-1.
    always_comb begin
        tail_sum = SUM_W'(head_q) + SUM_W'(count_q);
        if (tail_sum >= SUM_W'(DEPTH)) begin
            tail_sum = tail_sum - SUM_W'(DEPTH);
        end
        wr_slot_o = PTR_W'(tail_sum);
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXS_STOPPED;
            head_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            count_q <= count_d;
        end
    end

    // Outputs to the datapath and the flag.
    always_comb begin
        running_o    = (state_q == RXS_RUNNING);
        step_o.accept = accept;
        step_o.pop    = pop;
        step_o.rearm  = pop && (count_d != '0);
        rd_slot_o    = head_q;
        count_o      = count_q;
    end

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

    // R3
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !rd_i && (state_q != RXS_RUNNING || count_q == DEPTH_C) && !start_i && !stop_i)
        |=> $stable(count_q));

    // R7
    stopped_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXS_STOPPED) |=> $stable(head_q));

    // R7
    head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_q == RXS_RUNNING && count_q != '0 && head_q == LAST_SLOT)
        |=> (head_q == '0));

    // R10
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && byte_vld_i && state_q == RXS_RUNNING && count_q != '0 && count_q < DEPTH_C)
        |=> $stable(count_q));

endmodule

// File: rtl/rxq_event.sv
// Module: rxq_event
// Sticky data-ready flag. A set request wins over a clear. Only a write of
// all-zero data clears the flag.
// Assumes: set_i is a one-cycle request from the control block.
module rxq_event #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             wr_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output logic             flag_o
);

    logic flag_q, flag_d;

    // Next flag: a set request wins, otherwise only a zero write clears.
    always_comb begin
        flag_d = flag_q;
        if (wr_i && (wr_data_i == '0)) flag_d = 1'b0;
        if (set_i)                     flag_d = 1'b1;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(wr_i && (wr_data_i == '0)));

endmodule

// File: rtl/rx_byte_queue.sv
// Module: rx_byte_queue (top)
// Six-entry receive byte queue with a combinational data port, a free-space
// report and a sticky data-ready flag.
// Assumes: one byte is offered per strobe, bus strobes last one cycle and
// reset is synchronous and active low.
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start_i,
    input  logic              rx_stop_i,
    input  logic              rx_vld_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rxd_rd_i,
    output logic [DATA_W-1:0] rxd_o,
    input  logic              rdy_wr_i,
    input  logic [BUS_W-1:0]  rdy_wdata_i,
    output logic              rdy_flag_o,
    output logic [CNT_W-1:0]  space_o,
    output logic [CNT_W-1:0]  fill_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxq_step_t        step;
    logic             running;
    logic [PTR_W-1:0] wr_slot, rd_slot;
    logic [CNT_W-1:0] count;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (rx_start_i),
        .stop_i     (rx_stop_i),
        .byte_vld_i (rx_vld_i),
        .rd_i       (rxd_rd_i),
        .running_o  (running),
        .step_o     (step),
        .wr_slot_o  (wr_slot),
        .rd_slot_o  (rd_slot),
        .count_o    (count)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .wr_en_i   (step.accept),
        .wr_slot_i (wr_slot),
        .wr_data_i (rx_byte_i),
        .rd_slot_i (rd_slot),
        .rd_data_o (rxd_o)
    );

    rxq_event #(.BUS_W(BUS_W)) u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (step.accept | step.rearm),
        .wr_i      (rdy_wr_i),
        .wr_data_i (rdy_wdata_i),
        .flag_o    (rdy_flag_o)
    );

    // Free space offered to the receiver, zero while stopped.
    always_comb begin
        space_o = running ? (CNT_W'(DEPTH) - count) : '0;
        fill_o  = count;
    end

    // R12
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd_i && fill_o == '0 && !rx_vld_i) |=> (fill_o == '0));

endmodule

// File: tb/sim_rx_byte_queue.sv
// Directed bench for rx_byte_queue. It drives inputs on the falling edge and
// samples registered outputs on the next falling edge.
module sim_rx_byte_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_start_i, rx_stop_i, rx_vld_i, rxd_rd_i, rdy_wr_i;
    logic [7:0]  rx_byte_i;
    logic [31:0] rdy_wdata_i;
    logic [7:0]  rxd_o;
    logic        rdy_flag_o;
    logic [2:0]  space_o, fill_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] model_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rx_byte_queue u0 (
        .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start_i), .rx_stop_i(rx_stop_i),
        .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i), .rxd_rd_i(rxd_rd_i), .rxd_o(rxd_o),
        .rdy_wr_i(rdy_wr_i), .rdy_wdata_i(rdy_wdata_i), .rdy_flag_o(rdy_flag_o),
        .space_o(space_o), .fill_o(fill_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        rx_vld_i = 1'b1; rx_byte_i = b;
        @(negedge clk);
        rx_vld_i = 1'b0;
    endtask

    task automatic pop_chk(input string req);
        logic [7:0] exp;
        exp = model_q.pop_front();
        rxd_rd_i = 1'b1;
        #1 check(req, rxd_o, exp);
        @(negedge clk);
        rxd_rd_i = 1'b0;
    endtask

    task automatic flag_write(input logic [31:0] v);
        rdy_wr_i = 1'b1; rdy_wdata_i = v;
        @(negedge clk);
        rdy_wr_i = 1'b0;
    endtask

    task automatic strobe(input logic s, input logic p);
        rx_start_i = s; rx_stop_i = p;
        @(negedge clk);
        rx_start_i = 1'b0; rx_stop_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 fill", fill_o, 0);
        check("R1 space", space_o, 0);
        check("R1 flag", rdy_flag_o, 0);
    endtask

    task automatic t_stopped_drop();
        push(8'h11);
        check("R3 fill stopped", fill_o, 0);
        check("R3 flag stopped", rdy_flag_o, 0);
    endtask

    task automatic t_start();
        strobe(1'b1, 1'b0);
        check("R11 space after start", space_o, 6);
        check("R5 space empty", space_o, 6);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 6; i++) begin
            push(8'hA1 + 8'(i));
            model_q.push_back(8'hA1 + 8'(i));
            check("R2 fill", fill_o, i + 1);
            check("R5 space", space_o, 5 - i);
        end
        check("R4 flag", rdy_flag_o, 1);
        flag_write(32'h0);
        push(8'hEE);
        check("R3 fill full", fill_o, 6);
        check("R3 flag full", rdy_flag_o, 0);
    endtask

    task automatic t_flag_write();
        push(8'h00); // dropped, queue still full
        flag_write(32'h0);
        rx_vld_i = 1'b0;
        // set flag via rearm path later; here use nonzero write on a cleared flag
        flag_write(32'h5);
        check("R9 nonzero write keeps 0", rdy_flag_o, 0);
    endtask

    task automatic t_drain_rearm();
        for (int k = 0; k < 6; k++) begin
            pop_chk("R6 order");
            check("R7 fill after pop", fill_o, 5 - k);
            check("R8 rearm", rdy_flag_o, (k < 5) ? 1 : 0);
            if (k < 5) begin
                flag_write(32'h3);
                check("R9 nonzero write keeps 1", rdy_flag_o, 1);
                flag_write(32'h0);
                check("R9 zero write clears", rdy_flag_o, 0);
            end
        end
    endtask

    task automatic t_stale();
        rxd_rd_i = 1'b1;
        #1 check("R12 stale head byte", rxd_o, 8'hA1);
        @(negedge clk);
        rxd_rd_i = 1'b0;
        check("R12 fill", fill_o, 0);
        check("R12 flag", rdy_flag_o, 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 4; i++) begin
            push(8'hB1 + 8'(i)); model_q.push_back(8'hB1 + 8'(i));
        end
        pop_chk("R7 wrap pre");
        pop_chk("R7 wrap pre");
        for (int i = 4; i < 8; i++) begin
            push(8'hB1 + 8'(i)); model_q.push_back(8'hB1 + 8'(i));
        end
        check("R2 fill wrap", fill_o, 6);
        for (int i = 0; i < 6; i++) pop_chk("R7 wrap order");
        check("R7 empty after wrap", fill_o, 0);
    endtask

    task automatic t_simul();
        push(8'hC1); model_q.push_back(8'hC1);
        push(8'hC2); model_q.push_back(8'hC2);
        rx_vld_i = 1'b1; rx_byte_i = 8'hC3;
        model_q.push_back(8'hC3);
        pop_chk("R10 head during both");
        rx_vld_i = 1'b0;
        check("R10 fill", fill_o, 2);
        pop_chk("R10 order");
        pop_chk("R10 order");
    endtask

    task automatic t_stop();
        push(8'hD1); model_q.push_back(8'hD1);
        push(8'hD2); model_q.push_back(8'hD2);
        strobe(1'b0, 1'b1);
        check("R11 space stopped", space_o, 0);
        check("R11 data kept", fill_o, 2);
        rxd_rd_i = 1'b1;
        #1 check("R7 stopped read head", rxd_o, 8'hD1);
        @(negedge clk);
        rxd_rd_i = 1'b0;
        check("R7 no pop while stopped", fill_o, 2);
        push(8'hD9);
        check("R3 drop while stopped", fill_o, 2);
        strobe(1'b1, 1'b0);
        pop_chk("R11 order after restart");
        pop_chk("R11 order after restart");
    endtask

    task automatic t_both_strobes();
        strobe(1'b1, 1'b1);
        check("R11 stop wins", space_o, 0);
        strobe(1'b1, 1'b0);
        check("R5 space running", space_o, 6);
    endtask

    task automatic t_set_vs_clear();
        flag_write(32'h0);
        rdy_wr_i = 1'b1; rdy_wdata_i = 32'h0;
        push(8'hE1); model_q.push_back(8'hE1);
        rdy_wr_i = 1'b0;
        check("R9 set wins", rdy_flag_o, 1);
        pop_chk("R6 single");
    endtask

    task automatic t_reset_mid();
        push(8'hF1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_q.delete();
        check("R1 fill after reset", fill_o, 0);
        check("R1 space after reset", space_o, 0);
        check("R1 flag after reset", rdy_flag_o, 0);
    endtask

    // Stimulus sequence.
    initial begin
        rst_n = 1'b0; rx_start_i = 0; rx_stop_i = 0; rx_vld_i = 0; rxd_rd_i = 0;
        rdy_wr_i = 0; rx_byte_i = '0; rdy_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped_drop();
        t_start();
        t_fill();
        t_flag_write();
        t_drain_rearm();
        t_stale();
        t_wrap();
        t_simul();
        t_stop();
        t_both_strobes();
        t_set_vs_clear();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule